// File: doc/BRIEF.md
# Dual-Clock FIFO with Binary Flag Compare

This block carries data words from a producer running on one clock to a consumer running on a second, unrelated clock. The producer offers a word with a push strobe and is told to hold off by a full flag. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and takes it with a pop strobe.

Each side keeps its own position counter. The counter is one bit wider than the storage address, and it is held both as a plain binary count and as a Gray-coded copy. Only the Gray copy is passed to the other clock, through a two-stage flip-flop synchronizer. On arrival it is decoded back to binary, and the flag is formed from a binary compare. The full flag compares the extra wrap bit and the address bits. The empty flag compares the whole pointer. Both flags are registered in their own clock domain. The storage depth is a power of two, set by the address width.

Top module: `xclk_fifo`

## Requirements
- R1: While its reset is low, the write side shows `src_full`=0 and the read side shows `dst_empty`=1. Both pointers clear asynchronously to zero.
- R2: Words leave in the order they were accepted. While `dst_empty`=0, `dst_word` combinationally shows the oldest stored word.
- R3: A push is accepted only on a `src_clk` edge where `src_push`=1 and `src_full`=0. A push while full is ignored: no word is stored and the write pointer holds.
- R4: A pop is accepted only on a `dst_clk` edge where `dst_pop`=1 and `dst_empty`=0. A pop while empty is ignored and the read pointer holds.
- R5: With the read side idle, `src_full` rises on the same `src_clk` edge that accepts the word filling the last free slot. After a pop it falls within 4 `src_clk` cycles.
- R6: `dst_empty` rises on the `dst_clk` edge that takes the last stored word. After a push into an empty FIFO it falls within 4 `dst_clk` cycles.
- R7: A pointer is sent to the other domain only in Gray form, and that form changes by at most one bit per clock of its own domain.
- R8: The FIFO holds exactly 2^AW words. With AW=3, a burst of more than 8 pushes into an empty FIFO stores exactly 8.
- R9: The two resets may be released at different times. Words pushed while the read side is still in reset are delivered once that side leaves reset and its flag settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Write-side clock |
| src_rst_n | input | 1 | Write-side asynchronous reset, active low |
| src_push | input | 1 | Request to store `src_word` |
| src_word | input | DW | Word to store |
| src_full | output | 1 | No free slot, registered on `src_clk` |
| dst_clk | input | 1 | Read-side clock |
| dst_rst_n | input | 1 | Read-side asynchronous reset, active low |
| dst_pop | input | 1 | Request to take the shown word |
| dst_word | output | DW | Oldest stored word |
| dst_empty | output | 1 | No stored word, registered on `dst_clk` |

## Verification
The clocks run at periods that are not integer multiples of each other. A table of burst steps moves the FIFO through partial fill, overfill that must reject the excess, partial drain and over-drain. This tells correct counting and wrap-bit handling apart from off-by-one capacity or flag errors. Directed passes measure when each flag changes around the last slot and the last word, which separates a registered flag formed from the next pointer from one that lags a cycle. A staggered reset release, and a concurrent stream where the writer outruns the reader, check ordering under real crossing traffic.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
    // number of flops a pointer passes through when it crosses domains
    localparam int unsigned XF_SYNC_STAGES = 2;
endpackage

// File: rtl/xfifo_g2b.sv
module xfifo_g2b #(
    parameter int unsigned PW = 4
) (
    input  logic [PW-1:0] gray,
    output logic [PW-1:0] bin
);
    // binary bit i is the parity of all Gray bits from i upward
    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign bin[i] = ^gray[PW-1:i];
    end
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = d_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] peer_gray,
    output logic [PW-1:0] bin_q,
    output logic [PW-1:0] gray_q,
    output logic          full_q,
    output logic          fire
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
    } wst_t;

    localparam wst_t WST_RST = '{bin: '0, gray: '0, full: 1'b0};

    wst_t          st_d, st_q;
    logic [PW-1:0] peer_bin;

    xfifo_g2b #(.PW(PW)) i_g2b (.gray(peer_gray), .bin(peer_bin));

    always_comb begin
        st_d      = st_q;
        fire      = push & ~st_q.full;
        st_d.bin  = st_q.bin + PW'(fire);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        // full: wrap bits differ, address bits match
        st_d.full = (st_d.bin[PW-1] != peer_bin[PW-1]) &&
                    (st_d.bin[PW-2:0] == peer_bin[PW-2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WST_RST;
        else        st_q <= st_d;
    end

    assign bin_q  = st_q.bin;
    assign gray_q = st_q.gray;
    assign full_q = st_q.full;
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [PW-1:0] peer_gray,
    output logic [PW-1:0] bin_q,
    output logic [PW-1:0] gray_q,
    output logic          empty_q
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
    } rst_t;

    localparam rst_t RST_VAL = '{bin: '0, gray: '0, empty: 1'b1};

    rst_t          st_d, st_q;
    logic [PW-1:0] peer_bin;
    logic          take;

    xfifo_g2b #(.PW(PW)) i_g2b (.gray(peer_gray), .bin(peer_bin));

    always_comb begin
        st_d       = st_q;
        take       = pop & ~st_q.empty;
        st_d.bin   = st_q.bin + PW'(take);
        st_d.gray  = st_d.bin ^ (st_d.bin >> 1);
        st_d.empty = (st_d.bin == peer_bin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign bin_q   = st_q.bin;
    assign gray_q  = st_q.gray;
    assign empty_q = st_q.empty;
endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xfifo_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 8
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic          src_push,
    input  logic [DW-1:0] src_word,
    output logic          src_full,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    input  logic          dst_pop,
    output logic [DW-1:0] dst_word,
    output logic          dst_empty
);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] w_bin, w_gray, w_gray_s;
    logic [PW-1:0] r_bin, r_gray, r_gray_s;
    logic          w_fire;

    xfifo_wside #(.PW(PW)) i_wside (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .push      (src_push),
        .peer_gray (r_gray_s),
        .bin_q     (w_bin),
        .gray_q    (w_gray),
        .full_q    (src_full),
        .fire      (w_fire)
    );

    xfifo_rside #(.PW(PW)) i_rside (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .pop       (dst_pop),
        .peer_gray (w_gray_s),
        .bin_q     (r_bin),
        .gray_q    (r_gray),
        .empty_q   (dst_empty)
    );

    xfifo_sync #(.W(PW), .STAGES(XF_SYNC_STAGES)) i_w2r (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_in  (w_gray),
        .d_out (w_gray_s)
    );

    xfifo_sync #(.W(PW), .STAGES(XF_SYNC_STAGES)) i_r2w (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d_in  (r_gray),
        .d_out (r_gray_s)
    );

    xfifo_store #(.AW(AW), .DW(DW)) i_store (
        .clk   (src_clk),
        .we    (w_fire),
        .waddr (w_bin[AW-1:0]),
        .wdata (src_word),
        .raddr (r_bin[AW-1:0]),
        .rdata (dst_word)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int unsigned AW = 3
) (
    input logic          src_clk,
    input logic          src_rst_n,
    input logic          src_push,
    input logic          src_full,
    input logic          dst_clk,
    input logic          dst_rst_n,
    input logic          dst_pop,
    input logic          dst_empty,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_bin,
    input logic [AW:0]   r_gray
);
    localparam int unsigned PW = AW + 1;

    // R3: push while full leaves the write pointer where it was
    p_no_overflow_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_push && src_full) |=> $stable(w_bin));

    // R3: accepted push moves the write pointer by exactly one
    p_push_step_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_push && !src_full) |=> (w_bin == PW'($past(w_bin) + 1)));

    // R4: pop while empty leaves the read pointer where it was
    p_no_underflow_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_pop && dst_empty) |=> $stable(r_bin));

    // R4: accepted pop moves the read pointer by exactly one
    p_pop_step_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_pop && !dst_empty) |=> (r_bin == PW'($past(r_bin) + 1)));

    // R7: crossing copies change by at most one bit per own clock
    p_wgray_onebit_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    p_rgray_onebit_r7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW)) i_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_push  (src_push),
    .src_full  (src_full),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_pop   (dst_pop),
    .dst_empty (dst_empty),
    .w_bin     (w_bin),
    .w_gray    (w_gray),
    .r_bin     (r_bin),
    .r_gray    (r_gray)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/1ps
module test_xclk_fifo;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NSTEP = 8;
    // per step: pushes, pops, expected full, expected empty (DEPTH = 8)
    localparam int TBL [NSTEP][4] = '{
        '{3, 0, 0, 0}, '{0, 3, 0, 1}, '{10, 0, 1, 0}, '{0, 2, 0, 0},
        '{5, 0, 1, 0}, '{0, 10, 0, 1}, '{7, 4, 0, 0}, '{0, 3, 0, 1}
    };

    logic          src_clk = 0, dst_clk = 0;
    logic          src_rst_n = 0, dst_rst_n = 0;
    logic          src_push = 0, dst_pop = 0;
    logic [DW-1:0] src_word = '0;
    logic          src_full, dst_empty;
    logic [DW-1:0] dst_word;

    int            n_chk = 0, n_err = 0;
    int            acc_w, acc_r, occ;
    logic [DW-1:0] nxt = 8'h10;
    logic [DW-1:0] ref_q [$];

    always #2.5 src_clk = ~src_clk;   // 200 MHz
    always #3.65 dst_clk = ~dst_clk;

    xclk_fifo #(.AW(AW), .DW(DW)) i_xclk_fifo (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_push(src_push),
        .src_word(src_word), .src_full(src_full),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pop(dst_pop),
        .dst_word(dst_word), .dst_empty(dst_empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_burst(input int n);
        acc_w = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge src_clk);
            src_push = 1;
            if (!src_full) begin
                src_word = nxt;
                ref_q.push_back(nxt);
                nxt = nxt + 1;
                acc_w++;
            end else begin
                src_word = 8'hEE;   // must never come out (R3)
            end
        end
        @(negedge src_clk);
        src_push = 0;
    endtask

    task automatic pop_burst(input int n);
        logic [DW-1:0] exp_w;
        acc_r = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge dst_clk);
            dst_pop = 1;
            if (!dst_empty) begin
                exp_w = (ref_q.size() > 0) ? ref_q.pop_front() : 8'hXX;
                check(dst_word === exp_w, "R2 order", dst_word, exp_w);
                acc_r++;
            end
        end
        @(negedge dst_clk);
        dst_pop = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge dst_clk);
        repeat (6) @(negedge src_clk);
    endtask

    initial begin
        int cnt;
        // R1: reset state
        #12;
        check(src_full == 0, "R1 full in reset", src_full, 0);
        check(dst_empty == 1, "R1 empty in reset", dst_empty, 1);

        // R9: write side leaves reset first
        @(negedge src_clk); src_rst_n = 1;
        push_burst(2);
        repeat (4) @(negedge dst_clk);
        check(dst_empty == 1, "R9 empty held while read reset", dst_empty, 1);
        @(negedge dst_clk); dst_rst_n = 1;
        settle();
        check(dst_empty == 0, "R9 empty after staggered release", dst_empty, 0);
        pop_burst(2);
        check(acc_r == 2, "R9 words delivered", acc_r, 2);
        settle();

        // table of bursts (R3, R4, R5, R6, R8)
        occ = 0;
        for (int s = 0; s < NSTEP; s++) begin
            int ew, er;
            ew = (TBL[s][0] < DEPTH - occ) ? TBL[s][0] : DEPTH - occ;
            push_burst(TBL[s][0]);
            check(acc_w == ew, "R8 accepted pushes", acc_w, ew);
            occ += acc_w;
            settle();
            er = (TBL[s][1] < occ) ? TBL[s][1] : occ;
            pop_burst(TBL[s][1]);
            check(acc_r == er, "R4 accepted pops", acc_r, er);
            occ -= acc_r;
            settle();
            check(src_full == TBL[s][2], "R5 full after step", src_full, TBL[s][2]);
            check(dst_empty == TBL[s][3], "R6 empty after step", dst_empty, TBL[s][3]);
        end

        // R5: full rises on the filling edge, falls soon after a pop
        push_burst(DEPTH);
        check(src_full == 1, "R5 full on filling edge", src_full, 1);
        settle();
        pop_burst(1);
        cnt = 0;
        while (src_full && cnt < 20) begin @(negedge src_clk); cnt++; end
        check(cnt <= 4, "R5 full release latency", cnt, 4);
        pop_burst(DEPTH - 1);
        check(dst_empty == 1, "R6 empty on last take", dst_empty, 1);
        settle();
        // R6: empty release latency
        push_burst(1);
        cnt = 0;
        while (dst_empty && cnt < 20) begin @(negedge dst_clk); cnt++; end
        check(cnt <= 4, "R6 empty release latency", cnt, 4);
        pop_burst(1);
        settle();

        // R2/R3: concurrent stream, writer faster than reader
        fork
            push_burst(40);
            pop_burst(90);
        join
        settle();
        check(acc_r == acc_w, "R2 stream all words out", acc_r, acc_w);
        check(ref_q.size() == 0, "R3 no rejected word stored", ref_q.size(), 0);
        check(dst_empty == 1, "R6 empty after stream", dst_empty, 1);
        // R7 is covered by the Gray one-bit properties in the checker

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end
endmodule